// File: doc/BRIEF.md
# Virtual Carrier-Sense Timer with Busy-Channel Combiner

This block holds the virtual carrier-sense timer of a wireless MAC and derives from it, together with the transmit and receive PHY activity lines, a single channel-busy indication. The timer counts down in 100 ns units, driven by an internal prescaler that divides the core clock. It can be reloaded from two places: software may overwrite it with a wider value that is clipped to the counter range, and the duration field of the most recently received frame (in microseconds, multiplied by ten) may raise it when updates from received frames are enabled.

The channel-busy output is the OR of the timer being nonzero, transmit PHY activity and receive PHY activity. Each of the three sources can be masked on its own, and a force input pins the output high whatever the medium does. A disable input shuts the timer down: it reads zero while disabled and is left cleared when re-enabled. Extracting the duration field from frames happens upstream; this block only sees a value and a valid strobe.

Top module: `nav_cca_top`

## Requirements
- R1: While reset is asserted and after its release with all inputs low, nav_value is 0, nav_busy is 0 and cca_busy is 0.
- R2: With no load and no disable, nav_value decreases by exactly one every TICK_DIV clock cycles (default 10) and, once at zero, stays at zero.
- R3: A cycle with sw_set high loads sw_val into the timer at the next clock edge; a value above 2^NAV_W-1 (1048575 by default) loads 1048575.
- R4: A cycle with rx_dur_valid and rx_upd_en high loads rx_dur multiplied by DUR_SCALE (default 10), clipped to 2^NAV_W-1, but only when that product is strictly greater than the current value; otherwise the strobe is ignored.
- R5: A duration strobe while rx_upd_en is low has no effect on the timer.
- R6: When sw_set and an accepted duration strobe fall in the same cycle, the software value wins; any load also takes precedence over a prescaler tick in that cycle.
- R7: While nav_disable is high, nav_value reads 0 in the same cycle, all loads are ignored, and the timer is 0 when nav_disable is released.
- R8: nav_busy is high exactly when nav_value is nonzero.
- R9: cca_busy is the OR of nav_busy masked by ign_nav, tx_phy_active masked by ign_tx and rx_phy_active masked by ign_rx, each mask removing only its own source.
- R10: force_busy high makes cca_busy high regardless of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nav_disable | input | 1 | Shuts down and clears the timer |
| sw_set | input | 1 | One-cycle software load strobe |
| sw_val | input | 23 | Software load value, clipped to the timer range |
| rx_dur_valid | input | 1 | One-cycle strobe: a received duration is present |
| rx_upd_en | input | 1 | Allows received durations to load the timer |
| rx_dur | input | 16 | Received duration in microseconds |
| tx_phy_active | input | 1 | Transmit PHY is active |
| rx_phy_active | input | 1 | Receive PHY is active |
| ign_nav | input | 1 | Masks the timer from the busy flag |
| ign_tx | input | 1 | Masks transmit activity from the busy flag |
| ign_rx | input | 1 | Masks receive activity from the busy flag |
| force_busy | input | 1 | Forces the busy flag high |
| nav_value | output | 20 | Current timer value in 100 ns units |
| nav_busy | output | 1 | Timer is nonzero |
| cca_busy | output | 1 | Combined channel-busy flag |

## Verification
The collisions that matter are a software load landing in the same cycle as an accepted received duration, and either load landing on a prescaler tick. The bench drives both strobes together with a received product larger than the software value, and the random phase keeps firing strobes at every prescaler phase; a behavioural model that applies disable, then software, then received, then tick in that order judges every cycle, so a wrong priority or a decrement applied on top of a load shows up as a value mismatch right after the edge.

// File: rtl/nav_cca_pkg.sv
package nav_cca_pkg;

    // Which source the timer takes its next value from.
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_SW   = 2'd1,
        LD_RX   = 2'd2,
        LD_OFF  = 2'd3
    } nav_ld_e;

endpackage

// File: rtl/nav_tick_gen.sv
module nav_tick_gen #(
    parameter int TICK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            typedef struct packed {
                logic [CW-1:0] cnt;
            } pre_t;

            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            pre_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick_o = (st_q.cnt == LAST);

            // R2: the prescaler never leaves its range
            a_r2_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cnt <= LAST);
        end
    endgenerate

endmodule

// File: rtl/nav_load_sel.sv
module nav_load_sel
    import nav_cca_pkg::*;
#(
    parameter int NAV_W     = 20,
    parameter int SW_W      = 23,
    parameter int DUR_W     = 16,
    parameter int DUR_SCALE = 10
) (
    input  logic             off_i,
    input  logic             sw_set_i,
    input  logic [SW_W-1:0]  sw_val_i,
    input  logic             rx_valid_i,
    input  logic             rx_upd_en_i,
    input  logic [DUR_W-1:0] rx_dur_i,
    input  logic [NAV_W-1:0] cur_i,
    output nav_ld_e          kind_o,
    output logic [NAV_W-1:0] val_o
);
    localparam logic [NAV_W-1:0] NAV_MAX = '1;
    localparam logic [31:0]      MAX32   = 32'(NAV_MAX);

    logic [31:0]      sw32;
    logic [31:0]      rx32;
    logic [NAV_W-1:0] sw_clip;
    logic [NAV_W-1:0] rx_clip;
    logic             rx_take;

    always_comb begin
        sw32    = 32'(sw_val_i);
        rx32    = 32'(rx_dur_i) * 32'(DUR_SCALE);
        sw_clip = (sw32 > MAX32) ? NAV_MAX : sw32[NAV_W-1:0];
        rx_clip = (rx32 > MAX32) ? NAV_MAX : rx32[NAV_W-1:0];
        rx_take = rx_valid_i && rx_upd_en_i && (rx_clip > cur_i);

        kind_o = LD_NONE;
        val_o  = '0;
        if (off_i) begin
            kind_o = LD_OFF;
        end else if (sw_set_i) begin
            kind_o = LD_SW;
            val_o  = sw_clip;
        end else if (rx_take) begin
            kind_o = LD_RX;
            val_o  = rx_clip;
        end
    end

endmodule

// File: rtl/nav_counter.sv
module nav_counter
    import nav_cca_pkg::*;
#(
    parameter int NAV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  nav_ld_e          kind_i,
    input  logic [NAV_W-1:0] val_i,
    output logic [NAV_W-1:0] nav_o
);
    typedef struct packed {
        logic [NAV_W-1:0] nav;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            LD_OFF:  st_d.nav = '0;
            LD_SW,
            LD_RX:   st_d.nav = val_i;
            default: begin
                if (tick_i && (st_q.nav != '0)) begin
                    st_d.nav = st_q.nav - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nav_o = st_q.nav;

    // R2: a tick with no load takes exactly one unit off a nonzero timer
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == LD_NONE && tick_i && st_q.nav != '0)
        |=> (st_q.nav == $past(st_q.nav) - 1'b1));

    // R2: zero is a floor when nothing loads
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == LD_NONE && st_q.nav == '0) |=> (st_q.nav == '0));

    // R7: shutting down leaves the timer cleared
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == LD_OFF) |=> (st_q.nav == '0));

endmodule

// File: rtl/cca_combine.sv
module cca_combine (
    input  logic nav_busy_i,
    input  logic tx_act_i,
    input  logic rx_act_i,
    input  logic ign_nav_i,
    input  logic ign_tx_i,
    input  logic ign_rx_i,
    input  logic force_i,
    output logic busy_o
);
    logic [2:0] src;

    always_comb begin
        src[0] = nav_busy_i && !ign_nav_i;
        src[1] = tx_act_i   && !ign_tx_i;
        src[2] = rx_act_i   && !ign_rx_i;
        busy_o = force_i || (|src);
    end

endmodule

// File: rtl/nav_cca_top.sv
module nav_cca_top
    import nav_cca_pkg::*;
#(
    parameter int NAV_W     = 20,
    parameter int SW_W      = 23,
    parameter int DUR_W     = 16,
    parameter int DUR_SCALE = 10,
    parameter int TICK_DIV  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nav_disable,
    input  logic             sw_set,
    input  logic [SW_W-1:0]  sw_val,
    input  logic             rx_dur_valid,
    input  logic             rx_upd_en,
    input  logic [DUR_W-1:0] rx_dur,
    input  logic             tx_phy_active,
    input  logic             rx_phy_active,
    input  logic             ign_nav,
    input  logic             ign_tx,
    input  logic             ign_rx,
    input  logic             force_busy,
    output logic [NAV_W-1:0] nav_value,
    output logic             nav_busy,
    output logic             cca_busy
);
    localparam logic [NAV_W-1:0] NAV_MAX = '1;

    logic             tick;
    nav_ld_e          ld_kind;
    logic [NAV_W-1:0] ld_val;
    logic [NAV_W-1:0] nav_q;

    nav_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    nav_load_sel #(
        .NAV_W     (NAV_W),
        .SW_W      (SW_W),
        .DUR_W     (DUR_W),
        .DUR_SCALE (DUR_SCALE)
    ) u_sel (
        .off_i       (nav_disable),
        .sw_set_i    (sw_set),
        .sw_val_i    (sw_val),
        .rx_valid_i  (rx_dur_valid),
        .rx_upd_en_i (rx_upd_en),
        .rx_dur_i    (rx_dur),
        .cur_i       (nav_q),
        .kind_o      (ld_kind),
        .val_o       (ld_val)
    );

    nav_counter #(.NAV_W(NAV_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .kind_i (ld_kind),
        .val_i  (ld_val),
        .nav_o  (nav_q)
    );

    assign nav_value = nav_disable ? '0 : nav_q;
    assign nav_busy  = (nav_value != '0);

    cca_combine u_cca (
        .nav_busy_i (nav_busy),
        .tx_act_i   (tx_phy_active),
        .rx_act_i   (rx_phy_active),
        .ign_nav_i  (ign_nav),
        .ign_tx_i   (ign_tx),
        .ign_rx_i   (ign_rx),
        .force_i    (force_busy),
        .busy_o     (cca_busy)
    );

    // R10: forcing always shows at the busy output
    a_r10_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_busy |-> cca_busy);

    // R9: an unmasked transmit source alone makes the channel busy
    a_r9_tx_path: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_phy_active && !ign_tx) |-> cca_busy);

    // R7: the timer reads zero while shut down
    a_r7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nav_disable |-> (nav_value == '0 && !nav_busy));

    // R3: an oversized software value lands at the counter maximum
    a_r3_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (!nav_disable && sw_set && (32'(sw_val) > 32'(NAV_MAX)))
        |=> (nav_disable || nav_value == NAV_MAX));

    // R6: software beats a simultaneous received duration
    a_r6_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!nav_disable && sw_set && rx_dur_valid && rx_upd_en
         && (32'(sw_val) <= 32'(NAV_MAX)))
        |=> (nav_disable || nav_value == $past(sw_val[NAV_W-1:0])));

endmodule

// File: tb/tb_nav_cca_top.sv
`timescale 1ns/1ps
module tb_nav_cca_top;
    localparam int  NAV_MAX = 1048575;
    localparam int  DIV     = 10;
    localparam int  SCALE   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nav_disable = 0, sw_set = 0, rx_dur_valid = 0, rx_upd_en = 0;
    logic [22:0] sw_val = '0;
    logic [15:0] rx_dur = '0;
    logic        tx_phy_active = 0, rx_phy_active = 0;
    logic        ign_nav = 0, ign_tx = 0, ign_rx = 0, force_busy = 0;
    logic [19:0] nav_value;
    logic        nav_busy, cca_busy;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    int  m_pre = 0;
    int  m_nav = 0;

    always #5 clk = ~clk;

    nav_cca_top dut (
        .clk(clk), .rst_n(rst_n), .nav_disable(nav_disable),
        .sw_set(sw_set), .sw_val(sw_val), .rx_dur_valid(rx_dur_valid),
        .rx_upd_en(rx_upd_en), .rx_dur(rx_dur),
        .tx_phy_active(tx_phy_active), .rx_phy_active(rx_phy_active),
        .ign_nav(ign_nav), .ign_tx(ign_tx), .ign_rx(ign_rx),
        .force_busy(force_busy), .nav_value(nav_value),
        .nav_busy(nav_busy), .cca_busy(cca_busy)
    );

    function automatic int exp_nav();
        return nav_disable ? 0 : m_nav;
    endfunction

    function automatic bit exp_cca();
        bit nb;
        nb = (exp_nav() != 0);
        return force_busy || (nb && !ign_nav) || (tx_phy_active && !ign_tx)
               || (rx_phy_active && !ign_rx);
    endfunction

    // cycle model and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0;
            m_nav = 0;
        end else begin
            bit     tk;
            longint rxp;
            longint swv;
            tk    = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            swv   = longint'(sw_val);
            rxp   = longint'(rx_dur) * SCALE;
            if (swv > NAV_MAX) swv = NAV_MAX;
            if (rxp > NAV_MAX) rxp = NAV_MAX;
            if (nav_disable)                                   m_nav = 0;
            else if (sw_set)                                   m_nav = int'(swv);
            else if (rx_dur_valid && rx_upd_en && rxp > m_nav) m_nav = int'(rxp);
            else if (tk && m_nav > 0)                          m_nav = m_nav - 1;
        end
        #2;
        if (!done) begin
            vectors++;
            if (int'(nav_value) != exp_nav()) begin
                fails++;
                $display("FAIL R2 model nav_value got %0d exp %0d", nav_value, exp_nav());
            end
            if (nav_busy != (exp_nav() != 0)) begin
                fails++;
                $display("FAIL R8 model nav_busy got %0d exp %0d", nav_busy, exp_nav() != 0);
            end
            if (cca_busy != exp_cca()) begin
                fails++;
                $display("FAIL R9 model cca_busy got %0d exp %0d", cca_busy, exp_cca());
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #3;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic sw_load(input int v);
        sw_val = 23'(v);
        sw_set = 1;
        cyc();
        sw_set = 0;
    endtask

    task automatic rx_strobe(input int d, input bit en);
        rx_dur       = 16'(d);
        rx_upd_en    = en;
        rx_dur_valid = 1;
        cyc();
        rx_dur_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got 1 exp 0");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        chk("R1 nav_value in reset", nav_value, 0);
        chk("R1 cca_busy in reset", cca_busy, 0);
        rst_n = 1;
        cyc();
        chk("R1 nav_busy after reset", nav_busy, 0);

        // R3 load and R2 decrement
        sw_load(1000);
        chk("R3 software load", nav_value, 1000);
        repeat (DIV) cyc();
        chk("R2 one unit per tick period", nav_value, 999);

        // R3 clip
        sw_load(23'h7FFFFF);
        chk("R3 clip to max", nav_value, NAV_MAX);

        // R4 larger duration accepted, smaller ignored
        sw_load(100);
        rx_strobe(20, 1);
        chk("R4 larger duration loads", nav_value, 200);
        rx_strobe(5, 1);
        chk("R4 smaller duration ignored", int'(nav_value >= 199 && nav_value <= 200), 1);
        rx_strobe(16'hFFFF, 1);
        chk("R4 full-scale duration", nav_value, 655350);

        // R5 strobe without enable
        sw_load(300);
        rx_strobe(5000, 0);
        chk("R5 disabled update ignored", int'(nav_value >= 299 && nav_value <= 300), 1);

        // R6 both loads together
        sw_val = 23'd300; sw_set = 1;
        rx_dur = 16'd5000; rx_upd_en = 1; rx_dur_valid = 1;
        cyc();
        sw_set = 0; rx_dur_valid = 0;
        chk("R6 software wins", nav_value, 300);

        // R7 disable
        nav_disable = 1;
        #1;
        chk("R7 reads zero at once", nav_value, 0);
        chk("R7 busy low", nav_busy, 0);
        sw_load(50);
        rx_strobe(100, 1);
        chk("R7 loads ignored", nav_value, 0);
        nav_disable = 0;
        #1;
        chk("R7 cleared after release", nav_value, 0);

        // R8 busy follows value to zero, R2 floor
        sw_load(1);
        chk("R8 busy when nonzero", nav_busy, 1);
        repeat (DIV) cyc();
        chk("R2 reaches zero", nav_value, 0);
        chk("R8 idle at zero", nav_busy, 0);
        repeat (2 * DIV) cyc();
        chk("R2 floor at zero", nav_value, 0);

        // R9 masking
        tx_phy_active = 1; #1;
        chk("R9 tx source", cca_busy, 1);
        ign_tx = 1; #1;
        chk("R9 tx masked", cca_busy, 0);
        rx_phy_active = 1; #1;
        chk("R9 rx source", cca_busy, 1);
        ign_rx = 1; #1;
        chk("R9 rx masked", cca_busy, 0);
        sw_load(5000);
        chk("R9 nav source", cca_busy, 1);
        ign_nav = 1; #1;
        chk("R9 nav masked", cca_busy, 0);

        // R10 force
        force_busy = 1; #1;
        chk("R10 force with all masked", cca_busy, 1);
        force_busy = 0; ign_nav = 0; ign_tx = 0; ign_rx = 0;
        tx_phy_active = 0; rx_phy_active = 0;
        cyc();

        // random phase, judged by the per-cycle model
        for (int i = 0; i < 4000; i++) begin
            sw_set        = ($urandom_range(0, 40) == 0);
            sw_val        = ($urandom_range(0, 7) == 0) ? 23'($urandom) : 23'($urandom_range(0, 400));
            rx_dur_valid  = ($urandom_range(0, 15) == 0);
            rx_upd_en     = ($urandom_range(0, 3) != 0);
            rx_dur        = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 60));
            nav_disable   = ($urandom_range(0, 60) == 0);
            tx_phy_active = $urandom_range(0, 1);
            rx_phy_active = $urandom_range(0, 1);
            ign_nav       = ($urandom_range(0, 3) == 0);
            ign_tx        = ($urandom_range(0, 3) == 0);
            ign_rx        = ($urandom_range(0, 3) == 0);
            force_busy    = ($urandom_range(0, 20) == 0);
            cyc();
        end
        finish_run();
    end

endmodule